// File: doc/BRIEF.md
# Table-Driven Front-End Gain Control Loop

This block closes an automatic gain control loop around an external variable-gain amplifier that sits ahead of the converter. Each incoming 16-bit sample may first pass through a DC-removing high-pass stage. It is then squared and summed over a programmable number of samples. At the end of each interval the sum is dumped, shifted right, clipped to a 7-bit range and biased by an offset. The result addresses a 128-entry error table whose signed entry sets the loop step.

The step is scaled by a shift, with a fast mode that uses a smaller shift, and is added into a saturating 32-bit loop accumulator once per interval. The six top bits of the accumulator index a 64-entry gain table. Each gain entry holds a 6-bit amplifier code and a 16-bit digital gain. The digital gain passes through a selectable delay so that it lines up with the moment the analog gain change reaches the samples. It then multiplies the samples sent downstream. The loop can be frozen or cleared, either from a register bit or from a sync source, and the host writes both tables through one write port.

Top module: `fe_agc_top`

## Requirements
- R1: After reset the loop accumulator, the amplifier code, the digital gain, `out_o` and `out_valid_o` are all zero, and every entry of both tables is zero.
- R2: A cycle with `tbl_we_i` high and `tbl_sel_i` = 0 writes `tbl_wdata_i[7:0]` (signed two's complement) to error entry `tbl_addr_i`. With `tbl_sel_i` = 1 it writes gain entry `tbl_addr_i[5:0]`, where bits [21:16] are the amplifier code and bits [15:0] are the digital gain.
- R3: The power is the sum of squares of `intvl_len_i` consecutive valid samples (a length of 0 acts as 1). The error address is min(min(power >> `acc_shift_i`, 127) + `err_offset_i`, 127).
- R4: One cycle after each dump, the accumulator adds the error entry placed at bits [31:24], sign extended and arithmetically shifted right by `err_shift_i`. The result saturates at 0 and at 2^32-1, and the accumulator does not change outside dumps.
- R5: With `fast_i` high the shift used is `err_shift_i` minus 2, floored at 0.
- R6: While `freeze_reg_i` or `freeze_sync_i` is high, the accumulator holds its value through dumps.
- R7: While `clear_reg_i` or `clear_sync_i` is high, the accumulator is set to zero on the next edge, and this takes priority over freeze and over a dump.
- R8: One cycle after the accumulator changes, `vga_code_o` and `dgain_o` show the gain entry indexed by accumulator bits [31:26].
- R9: Each valid sample produces, one cycle later, `out_valid_o` high and `out_o` = sample × gain / 32768, with the gain unsigned (32768 = 1.0), rounded half up and saturated to the signed 16-bit range. `out_o` holds when no sample arrives.
- R10: The gain used by the multiplier lags `dgain_o` by `dly_adj_i` cycles, so a gain change reaches `out_o` `dly_adj_i`+1 cycles after it appears on `dgain_o`.
- R11: With `hpf_en_i` high, a constant input settles to a filtered value of zero, so a settled interval measures zero power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_valid_i | input | 1 | Sample strobe |
| samp_i | input | DATA_W | Signed input sample |
| hpf_en_i | input | 1 | Enable DC-removing high-pass before squaring |
| intvl_len_i | input | CNT_W | Samples per integration interval |
| acc_shift_i | input | SHIFT_W | Right shift applied to dumped power |
| err_offset_i | input | 7 | Offset added to the limited power |
| err_shift_i | input | ESH_W | Right shift applied to the table error |
| fast_i | input | 1 | Fast update: smaller error shift |
| freeze_reg_i | input | 1 | Freeze from register bit |
| freeze_sync_i | input | 1 | Freeze from sync source |
| clear_reg_i | input | 1 | Clear from register bit |
| clear_sync_i | input | 1 | Clear from sync source |
| dly_adj_i | input | DLY_W | Digital gain delay in cycles |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_sel_i | input | 1 | 0 = error table, 1 = gain table |
| tbl_addr_i | input | 7 | Table write address |
| tbl_wdata_i | input | 22 | Table write data |
| vga_code_o | output | 6 | Amplifier gain code |
| dgain_o | output | 16 | Undelayed digital gain |
| loop_acc_o | output | ACC_W | Loop accumulator |
| out_valid_o | output | 1 | Output sample strobe |
| out_o | output | DATA_W | Gain-corrected output sample |

## Verification
The bench builds the block with CNT_W = 8 and uses a four-sample interval, so a full dump-and-update cycle takes only a few clocks. Both saturation bounds of the accumulator and the high-pass settling time then fit in a few hundred cycles. All other parameters keep their defaults. The full 32-bit accumulator, the 31-tap gain delay and the 57-bit power sum therefore run at their production widths, and a zero error shift reaches the top index of the gain table within three intervals.

// File: rtl/fe_agc_pkg.sv
package fe_agc_pkg;
  localparam int VGA_W   = 6;
  localparam int DG_W    = 16;
  localparam int ERR_W   = 8;
  localparam int ERR_AW  = 7;
  localparam int GAIN_AW = 6;
  localparam int GE_W    = VGA_W + DG_W;

  typedef struct packed {
    logic [VGA_W-1:0] vga;
    logic [DG_W-1:0]  dgain;
  } gain_entry_t;
endpackage

// File: rtl/fe_agc_power.sv
module fe_agc_power
  import fe_agc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 21,
  parameter int PWR_W       = 57,
  parameter int HPF_SHIFT   = 4,
  parameter int HPF_PRESENT = 1,
  parameter int SHIFT_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_valid_i,
  input  logic [DATA_W-1:0] samp_i,
  input  logic              hpf_en_i,
  input  logic [CNT_W-1:0]  intvl_len_i,
  input  logic [SHIFT_W-1:0] acc_shift_i,
  input  logic [ERR_AW-1:0] err_offset_i,
  output logic              dump_o,
  output logic [ERR_AW-1:0] addr_o
);
  localparam int SQ_W     = 2*DATA_W - 1;
  localparam int DC_W     = DATA_W + HPF_SHIFT + 1;
  localparam int ADDR_MAX = 2**ERR_AW - 1;

  logic signed [DATA_W-1:0] hp;
  logic signed [2*DATA_W-1:0] prod;
  logic [SQ_W-1:0] sq;

  generate
    if (HPF_PRESENT != 0) begin : g_hpf
      logic signed [DC_W-1:0] dc_q;
      logic signed [DC_W-1:0] dc_lvl;
      logic signed [DC_W:0]   diff;
      logic signed [DATA_W-1:0] hp_sat;

      assign dc_lvl = dc_q >>> HPF_SHIFT;
      assign diff = {{(DC_W+1-DATA_W){samp_i[DATA_W-1]}}, samp_i} - {dc_lvl[DC_W-1], dc_lvl};

      always_comb begin
        if (diff[DC_W:DATA_W-1] == '0 || diff[DC_W:DATA_W-1] == '1)
          hp_sat = diff[DATA_W-1:0];
        else if (diff[DC_W])
          hp_sat = {1'b1, {(DATA_W-1){1'b0}}};
        else
          hp_sat = {1'b0, {(DATA_W-1){1'b1}}};
      end

      assign hp = hpf_en_i ? hp_sat : samp_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            dc_q <= '0;
        else if (!hpf_en_i)     dc_q <= '0;
        else if (samp_valid_i)  dc_q <= dc_q + {{(DC_W-DATA_W){hp[DATA_W-1]}}, hp};
      end
    end else begin : g_no_hpf
      assign hp = samp_i;
    end
  endgenerate

  assign prod = hp * hp;
  assign sq   = prod[SQ_W-1:0];

  // integrate and dump
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic [PWR_W-1:0] sum_q, sum_nxt, power_q;
  logic             dump_q;

  assign last_idx = (intvl_len_i == '0) ? '0 : intvl_len_i - 1'b1;
  assign sum_nxt  = sum_q + PWR_W'(sq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sum_q   <= '0;
      power_q <= '0;
      dump_q  <= 1'b0;
    end else begin
      dump_q <= 1'b0;
      if (samp_valid_i) begin
        if (cnt_q >= last_idx) begin
          cnt_q   <= '0;
          sum_q   <= '0;
          power_q <= sum_nxt;
          dump_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sum_q <= sum_nxt;
        end
      end
    end
  end

  // shift, limit, bias
  logic [PWR_W-1:0]  shifted;
  logic [ERR_AW-1:0] lim;
  logic [ERR_AW:0]   biased;

  assign shifted = power_q >> acc_shift_i;
  assign lim     = (shifted > PWR_W'(ADDR_MAX)) ? ERR_AW'(ADDR_MAX) : shifted[ERR_AW-1:0];
  assign biased  = {1'b0, lim} + {1'b0, err_offset_i};
  assign addr_o  = biased[ERR_AW] ? '1 : biased[ERR_AW-1:0];
  assign dump_o  = dump_q;

  assert_dump_after_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_q |-> $past(samp_valid_i));
endmodule

// File: rtl/fe_agc_loop.sv
module fe_agc_loop
  import fe_agc_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int ESH_W     = 5,
  parameter int FAST_DROP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dump_i,
  input  logic [ERR_AW-1:0] addr_i,
  input  logic [ESH_W-1:0]  err_shift_i,
  input  logic              fast_i,
  input  logic              freeze_i,
  input  logic              clear_i,
  input  logic              tbl_we_i,
  input  logic              tbl_sel_i,
  input  logic [ERR_AW-1:0] tbl_addr_i,
  input  logic [GE_W-1:0]   tbl_wdata_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [VGA_W-1:0]  vga_o,
  output logic [DG_W-1:0]   dgain_o
);
  localparam int ERR_DEPTH  = 2**ERR_AW;
  localparam int GAIN_DEPTH = 2**GAIN_AW;

  logic signed [ERR_W-1:0] err_mem [ERR_DEPTH];
  gain_entry_t             gain_mem [GAIN_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ERR_DEPTH; i++)  err_mem[i]  <= '0;
      for (int i = 0; i < GAIN_DEPTH; i++) gain_mem[i] <= '0;
    end else if (tbl_we_i) begin
      if (tbl_sel_i) gain_mem[tbl_addr_i[GAIN_AW-1:0]] <= tbl_wdata_i;
      else           err_mem[tbl_addr_i]               <= tbl_wdata_i[ERR_W-1:0];
    end
  end

  // step scaling
  logic [ESH_W-1:0]        eff_shift;
  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W+1:0] err_top, step, sum_wide;
  logic [ACC_W-1:0]        acc_q, acc_sat;

  always_comb begin
    if (fast_i)
      eff_shift = (err_shift_i > ESH_W'(FAST_DROP)) ? err_shift_i - ESH_W'(FAST_DROP) : '0;
    else
      eff_shift = err_shift_i;
  end

  assign err      = err_mem[addr_i];
  assign err_top  = {{2{err[ERR_W-1]}}, err, {(ACC_W-ERR_W){1'b0}}};
  assign step     = err_top >>> eff_shift;
  assign sum_wide = $signed({2'b00, acc_q}) + step;

  always_comb begin
    if (sum_wide[ACC_W+1])  acc_sat = '0;
    else if (sum_wide[ACC_W]) acc_sat = '1;
    else                    acc_sat = sum_wide[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_q <= '0;
    else if (clear_i)            acc_q <= '0;
    else if (dump_i && !freeze_i) acc_q <= acc_sat;
  end

  // gain map lookup
  logic [GAIN_AW-1:0] idx;
  gain_entry_t        gain_q;

  assign idx = acc_q[ACC_W-1 -: GAIN_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= '0;
    else         gain_q <= gain_mem[idx];
  end

  assign acc_o   = acc_q;
  assign vga_o   = gain_q.vga;
  assign dgain_o = gain_q.dgain;

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dump_i && !clear_i) |=> (acc_q == $past(acc_q)));
  assert_freeze_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clear_i) |=> (acc_q == $past(acc_q)));
  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0));
  assert_gain_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tbl_we_i) && idx == $past(idx)) |=> $stable(gain_q));
endmodule

// File: rtl/fe_agc_gain_apply.sv
module fe_agc_gain_apply #(
  parameter int DATA_W = 16,
  parameter int DG_W   = 16,
  parameter int DLY_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_valid_i,
  input  logic [DATA_W-1:0] samp_i,
  input  logic [DG_W-1:0]   dgain_i,
  input  logic [DLY_W-1:0]  dly_adj_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_o
);
  localparam int DLY_N = 2**DLY_W - 1;
  localparam int FRAC  = DG_W - 1;
  localparam int P_W   = DATA_W + DG_W + 1;

  logic [DG_W-1:0] dly_q [DLY_N];

  generate
    for (genvar g = 0; g < DLY_N; g++) begin : g_tap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q[g] <= '0;
        else if (g == 0) dly_q[g] <= dgain_i;
        else             dly_q[g] <= dly_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  logic [DG_W-1:0]       gsel;
  logic signed [P_W-1:0] prod, rnd, shr;
  logic [DATA_W-1:0]     sat;

  assign gsel = (dly_adj_i == '0) ? dgain_i : dly_q[dly_adj_i - 1'b1];
  assign prod = $signed(samp_i) * $signed({1'b0, gsel});
  assign rnd  = prod + P_W'(2**(FRAC-1));
  assign shr  = rnd >>> FRAC;

  always_comb begin
    if (shr[P_W-1:DATA_W-1] == '0 || shr[P_W-1:DATA_W-1] == '1)
      sat = shr[DATA_W-1:0];
    else if (shr[P_W-1])
      sat = {1'b1, {(DATA_W-1){1'b0}}};
    else
      sat = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_o       <= '0;
    end else begin
      out_valid_o <= samp_valid_i;
      if (samp_valid_i) out_o <= sat;
    end
  end

  assert_out_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_valid_i |=> out_valid_o);
  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_valid_i |=> (!out_valid_o && $stable(out_o)));
endmodule

// File: rtl/fe_agc_top.sv
module fe_agc_top
  import fe_agc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 21,
  parameter int PWR_W       = 57,
  parameter int ACC_W       = 32,
  parameter int HPF_SHIFT   = 4,
  parameter int HPF_PRESENT = 1,
  parameter int SHIFT_W     = 6,
  parameter int ESH_W       = 5,
  parameter int FAST_DROP   = 2,
  parameter int DLY_W       = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               samp_valid_i,
  input  logic [DATA_W-1:0]  samp_i,
  input  logic               hpf_en_i,
  input  logic [CNT_W-1:0]   intvl_len_i,
  input  logic [SHIFT_W-1:0] acc_shift_i,
  input  logic [ERR_AW-1:0]  err_offset_i,
  input  logic [ESH_W-1:0]   err_shift_i,
  input  logic               fast_i,
  input  logic               freeze_reg_i,
  input  logic               freeze_sync_i,
  input  logic               clear_reg_i,
  input  logic               clear_sync_i,
  input  logic [DLY_W-1:0]   dly_adj_i,
  input  logic               tbl_we_i,
  input  logic               tbl_sel_i,
  input  logic [ERR_AW-1:0]  tbl_addr_i,
  input  logic [GE_W-1:0]    tbl_wdata_i,
  output logic [VGA_W-1:0]   vga_code_o,
  output logic [DG_W-1:0]    dgain_o,
  output logic [ACC_W-1:0]   loop_acc_o,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  out_o
);
  logic              dump;
  logic [ERR_AW-1:0] err_addr;
  logic              freeze_any, clear_any;

  assign freeze_any = freeze_reg_i | freeze_sync_i;
  assign clear_any  = clear_reg_i | clear_sync_i;

  fe_agc_power #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PWR_W(PWR_W),
    .HPF_SHIFT(HPF_SHIFT), .HPF_PRESENT(HPF_PRESENT), .SHIFT_W(SHIFT_W)
  ) u_power (
    .clk_i, .rst_ni, .samp_valid_i, .samp_i, .hpf_en_i, .intvl_len_i,
    .acc_shift_i, .err_offset_i,
    .dump_o(dump), .addr_o(err_addr)
  );

  fe_agc_loop #(
    .ACC_W(ACC_W), .ESH_W(ESH_W), .FAST_DROP(FAST_DROP)
  ) u_loop (
    .clk_i, .rst_ni,
    .dump_i(dump), .addr_i(err_addr), .err_shift_i, .fast_i,
    .freeze_i(freeze_any), .clear_i(clear_any),
    .tbl_we_i, .tbl_sel_i, .tbl_addr_i, .tbl_wdata_i,
    .acc_o(loop_acc_o), .vga_o(vga_code_o), .dgain_o(dgain_o)
  );

  fe_agc_gain_apply #(
    .DATA_W(DATA_W), .DG_W(DG_W), .DLY_W(DLY_W)
  ) u_apply (
    .clk_i, .rst_ni, .samp_valid_i, .samp_i,
    .dgain_i(dgain_o), .dly_adj_i,
    .out_valid_o, .out_o
  );
endmodule

// File: tb/fe_agc_top_tb_top.sv
`timescale 1ns/1ps
module fe_agc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [15:0] samp = '0;
  logic        hpf_en = 1'b0;
  logic [7:0]  intvl_len = 8'd4;
  logic [5:0]  acc_shift = '0;
  logic [6:0]  err_offset = '0;
  logic [4:0]  err_shift = '0;
  logic        fast = 1'b0;
  logic        freeze_reg = 1'b0, freeze_sync = 1'b0;
  logic        clear_reg = 1'b0, clear_sync = 1'b0;
  logic [4:0]  dly_adj = '0;
  logic        tbl_we = 1'b0, tbl_sel = 1'b0;
  logic [6:0]  tbl_addr = '0;
  logic [21:0] tbl_wdata = '0;
  logic [5:0]  vga_code;
  logic [15:0] dgain;
  logic [31:0] loop_acc;
  logic        out_valid;
  logic [15:0] out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fe_agc_top #(.CNT_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .samp_valid_i(samp_valid), .samp_i(samp),
    .hpf_en_i(hpf_en), .intvl_len_i(intvl_len), .acc_shift_i(acc_shift),
    .err_offset_i(err_offset), .err_shift_i(err_shift), .fast_i(fast),
    .freeze_reg_i(freeze_reg), .freeze_sync_i(freeze_sync),
    .clear_reg_i(clear_reg), .clear_sync_i(clear_sync), .dly_adj_i(dly_adj),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr),
    .tbl_wdata_i(tbl_wdata), .vga_code_o(vga_code), .dgain_o(dgain),
    .loop_acc_o(loop_acc), .out_valid_o(out_valid), .out_o(out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send4(input int a, input int b, input int c, input int d);
    int v[4];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); samp_valid = 1'b1; samp = v[i][15:0];
    end
    @(negedge clk); samp_valid = 1'b0;
    idle(4);
  endtask

  task automatic send_block(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); samp_valid = 1'b1; samp = v[15:0];
    end
    @(negedge clk); samp_valid = 1'b0;
    idle(4);
  endtask

  // one sample, returns the output seen one cycle later
  task automatic send_one(input int v, output int res, output bit vld);
    @(negedge clk); samp_valid = 1'b1; samp = v[15:0];
    @(negedge clk); samp_valid = 1'b0;
    res = int'($signed(out)); vld = out_valid;
  endtask

  task automatic clear_acc();
    @(negedge clk); clear_reg = 1'b1;
    @(negedge clk); clear_reg = 1'b0;
    idle(2);
  endtask

  task automatic set_basic();
    acc_shift = 6'd12; err_offset = 7'd5; err_shift = 5'd8; fast = 1'b0; hpf_en = 1'b0;
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1", "acc", loop_acc, 0);
    chk("R1", "vga", vga_code, 0);
    chk("R1", "dgain", dgain, 0);
    chk("R1", "out", out, 0);
    chk("R1", "out_valid", out_valid, 0);
  endtask

  task automatic t_load();
    for (int a = 0; a < 128; a++) begin
      @(negedge clk); tbl_we = 1'b1; tbl_sel = 1'b0; tbl_addr = 7'(a);
      tbl_wdata = 22'(8'(a - 16));
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); tbl_we = 1'b1; tbl_sel = 1'b1; tbl_addr = 7'(i);
      tbl_wdata = {6'(63 - i), 16'(16'h4000 + i * 16'h200)};
    end
    @(negedge clk); tbl_we = 1'b0;
    idle(2);
    chk("R2", "vga entry0", vga_code, 63);
    chk("R2", "dgain entry0", dgain, 16'h4000);
  endtask

  task automatic t_basic();
    set_basic(); clear_acc();
    send4(100, -200, 300, 0);   // 140000 >>12 = 34, +5 -> 39, err 23
    chk("R3", "basic acc", loop_acc, 23 * 65536);
    chk("R4", "positive step", loop_acc, 1507328);
  endtask

  task automatic t_limit();
    set_basic(); acc_shift = 6'd0; clear_acc();
    send4(30000, 30000, 30000, 30000);  // limit 127, +5 saturates to 127, err 111
    chk("R3", "limit and offset saturate", loop_acc, 111 * 65536);
  endtask

  task automatic t_fast();
    set_basic(); fast = 1'b1; clear_acc();
    send4(100, -200, 300, 0);
    chk("R5", "fast step", loop_acc, 23 * 262144);
    fast = 1'b0;
  endtask

  task automatic t_freeze();
    set_basic(); clear_acc();
    send4(100, -200, 300, 0);
    freeze_reg = 1'b1;
    send4(100, -200, 300, 0);
    chk("R6", "freeze reg", loop_acc, 1507328);
    freeze_reg = 1'b0; freeze_sync = 1'b1;
    send4(100, -200, 300, 0);
    chk("R6", "freeze sync", loop_acc, 1507328);
    freeze_sync = 1'b0;
    send4(100, -200, 300, 0);
    chk("R6", "release", loop_acc, 2 * 1507328);
  endtask

  task automatic t_clear();
    @(negedge clk); clear_sync = 1'b1; freeze_reg = 1'b1;
    @(negedge clk); clear_sync = 1'b0; freeze_reg = 1'b0;
    idle(1);
    chk("R7", "clear sync over freeze", loop_acc, 0);
    set_basic();
    send4(100, -200, 300, 0);
    @(negedge clk); clear_reg = 1'b1;
    @(negedge clk); clear_reg = 1'b0;
    chk("R7", "clear reg", loop_acc, 0);
  endtask

  task automatic t_sat_high_out();
    int r; bit v;
    set_basic(); acc_shift = 6'd0; err_shift = 5'd0; clear_acc();
    send4(30000, 30000, 30000, 30000);
    send4(30000, 30000, 30000, 30000);
    chk("R4", "two big steps", loop_acc, 64'd3724541952);
    send4(30000, 30000, 30000, 30000);
    chk("R4", "upper saturation", loop_acc, 64'hFFFF_FFFF);
    chk("R8", "vga at index 63", vga_code, 0);
    chk("R8", "dgain at index 63", dgain, 16'hBE00);
    send_one(30000, r, v);
    chk("R9", "out positive saturation", r, 32767);
    chk("R9", "out valid", v, 1);
    send_one(-30000, r, v);
    chk("R9", "out negative saturation", r, -32768);
    send_one(1000, r, v);
    chk("R9", "out gain 1.484", r, 1484);
    send_one(0, r, v);
    idle(4);
  endtask

  task automatic t_sat_low();
    acc_shift = 6'd0; err_offset = 7'd0; err_shift = 5'd0;
    send4(0, 0, 0, 0);   // addr 0, err -16
    chk("R4", "negative step", loop_acc, 64'hEFFF_FFFF);
    for (int i = 0; i < 16; i++) send4(0, 0, 0, 0);
    chk("R4", "lower saturation", loop_acc, 0);
  endtask

  task automatic t_half_gain();
    int r; bit v;
    clear_acc(); idle(40);
    chk("R8", "dgain index 0", dgain, 16'h4000);
    send_one(1001, r, v);
    chk("R9", "1001 x 0.5", r, 501);
    send_one(-1001, r, v);
    chk("R9", "-1001 x 0.5", r, -500);
    send_one(1, r, v);
    chk("R9", "round up", r, 1);
    send_one(-1, r, v);
    chk("R9", "round half up negative", r, 0);
    idle(4);
    chk("R9", "valid drops", out_valid, 0);
  endtask

  task automatic t_delay(input int d);
    int ca, co, first_new;
    bit seen;
    acc_shift = 6'd0; err_offset = 7'd0; err_shift = 5'd0; hpf_en = 1'b0;
    dly_adj = 5'(d);
    clear_acc(); idle(40);
    ca = -1; co = -1; seen = 1'b0; first_new = 0;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      if (ca < 0 && dgain != 16'h4000) ca = c;
      if (int'($signed(out)) == 500) seen = 1'b1;
      if (co < 0 && seen && int'($signed(out)) != 500) begin
        co = c; first_new = int'($signed(out));
      end
      samp_valid = (c < 12); samp = 16'd1000;
    end
    samp_valid = 1'b0;
    idle(4);
    chk("R10", $sformatf("gain lag at delay %0d", d), co - ca, d + 1);
    chk("R9", "first output after gain change", first_new, 922);
    dly_adj = '0;
  endtask

  task automatic t_hpf();
    acc_shift = 6'd0; err_offset = 7'd20; err_shift = 5'd8; hpf_en = 1'b1;
    send_block(1000, 400);
    clear_acc();
    send4(1000, 1000, 1000, 1000);   // zero power -> addr 20, err 4
    chk("R11", "settled hpf power", loop_acc, 4 * 65536);
    hpf_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_basic();
    t_limit();
    t_fast();
    t_freeze();
    t_clear();
    t_sat_high_out();
    t_sat_low();
    t_half_gain();
    t_delay(0);
    t_delay(3);
    t_hpf();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule